// File: doc/BRIEF.md
# Multiplexed GPIO Pin Bank

This block is a bank of up to 32 general-purpose pins controlled through a small word-indexed register port. Software chooses, for every pin, whether it is driven or left as an input, what level it drives, whether a pull resistor is engaged and in which direction, and which of sixteen alternate functions the pad is steered to. The bank presents these settings to the pad ring as plain per-pin control vectors and returns the pad levels, after synchronisation, through an input register.

The register port uses a 4-bit word index. A byte address is four times the index. Writes take effect at the clock edge where `bus_we` is sampled high. Reads are registered, so data appears on `bus_rdata` one cycle after `bus_re`. Besides whole-word writes to the function-select words, a dedicated field-set register lets software change a single pin's function code in one write, without a read-modify-write.

Register indices: 0 direction, 1 output level, 2 pad input (read-only), 3 pull enable, 4 pull-up select, 5 function field-set (write-only), 8 upward for the function-select words, one word per eight pins.

Top module: `gpio_bank_mux`

## Requirements
- R1: After reset every direction bit of an existing pin is 1, and the output level, pull-enable, pull-up and all function fields are 0. Consequently `pad_oe`, `pad_out` and `pad_func` are all zero.
- R2: Direction register (index 0): a 1 makes the pin an input with `pad_oe` low, and a 0 makes it a driven output with `pad_oe` high.
- R3: `pad_out` for pin p equals bit p of the output-level register (index 1) while that pin's direction bit is 0, and is 0 while it is 1.
- R4: The pull-enable register (index 3) drives `pad_pull_en` and the pull-select register (index 4) drives `pad_pull_up`, one bit per pin. A select bit of 1 means pull-up and 0 means pull-down.
- R5: Pin p has a 4-bit function code (0 to 15) at bits 4*(p mod 8)+3 down to 4*(p mod 8) of the word at index 8 + p/8. The code appears on `pad_func[4p+3:4p]`.
- R6: A write to index 5 with pin number in bits 12:8 and code in bits 3:0 replaces only that pin's function field and leaves every other field unchanged. A pin number of NUM_PINS or above changes nothing, and index 5 reads as zero.
- R7: Index 2 returns the pad levels through a two-flop synchroniser. After `pad_in` changes, reads sampled at the first two rising edges return the old level, and reads sampled at the third edge and later return the new level. Writes to index 2 have no effect.
- R8: A read sampled at a rising edge places its data on `bus_rdata` after that edge. `bus_rdata` holds its value in every cycle with no read.
- R9: Indices 6 and 7, and every index above the last function-select word, read as zero, and writes to them change no register.
- R10: Register bits that belong to pins at or above NUM_PINS are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_idx | input | 4 | Register word index (byte address / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Output level toward the pads |
| pad_oe | output | NUM_PINS | Output enable toward the pads, high to drive |
| pad_pull_en | output | NUM_PINS | Pull resistor enable |
| pad_pull_up | output | NUM_PINS | Pull direction, 1 up, 0 down |
| pad_func | output | 4*NUM_PINS | Alternate-function code per pin |

## Verification
The bench builds the bank with NUM_PINS set to 20 rather than the full 32. This leaves twelve unimplemented bits in every one-bit-per-pin register and makes the third function-select word only half populated. As a result, the masking of absent pins, the partially filled mux word and an unmapped index just past the last mux word (index 11) can all be observed at the ports. The same build lets field-set writes name a pin number that lies outside the bank while still fitting the 5-bit field, so that the ignored case is exercised.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register indices, field geometry and helpers for the GPIO bank.
// Assumes a 4-bit word index and 32-bit data words throughout.
package gpio_bank_pkg;

    localparam int IDX_W      = 4;
    localparam int DATA_W     = 32;
    localparam int FN_W       = 4;
    localparam int FN_PER_WRD = DATA_W / FN_W;
    localparam int MAX_PINS   = 32;
    localparam int PIN_NUM_W  = 5;
    localparam int FNSET_LSB  = 8;

    localparam logic [IDX_W-1:0] IDX_DIR   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_OUT   = 4'd1;
    localparam logic [IDX_W-1:0] IDX_IN    = 4'd2;
    localparam logic [IDX_W-1:0] IDX_PEN   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_PUP   = 4'd4;
    localparam logic [IDX_W-1:0] IDX_FNSET = 4'd5;
    localparam logic [IDX_W-1:0] IDX_MUX0  = 4'd8;

    // Mask covering the function field of one pin in a flat field vector.
    function automatic logic [MAX_PINS*FN_W-1:0] fn_field_mask(input logic [PIN_NUM_W-1:0] pin);
        logic [MAX_PINS*FN_W-1:0] m;
        m = '0;
        m[FN_W-1:0] = '1;
        return m << (int'(pin) * FN_W);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pad levels.
// Assumes each bit is independent; no multi-bit coherency is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bit_reg.sv
// Module: one-bit-per-pin control register with a whole-word write.
// Assumes the caller has already decoded the index into a write enable.
module gpio_bit_reg #(
    parameter int         W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load on write, return to reset value under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/gpio_mux_fields.sv
// Module: per-pin 4-bit alternate-function fields.
// Each field is loaded either from its packed mux word or from the
// single-field set register. Assumes NUM_PINS <= 32.
module gpio_mux_fields
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_PINS*FN_W-1:0] func
);
    logic fnset_hit;
    logic [PIN_NUM_W-1:0] fnset_pin;
    logic [FN_W-1:0]      fnset_code;

    // Decode the field-set request once for all pins.
    always_comb begin
        fnset_hit  = we && (idx == IDX_FNSET);
        fnset_pin  = wdata[FNSET_LSB +: PIN_NUM_W];
        fnset_code = wdata[FN_W-1:0];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [IDX_W-1:0] WIDX = IDX_W'(int'(IDX_MUX0) + p / FN_PER_WRD);
        localparam int LSB = FN_W * (p % FN_PER_WRD);
        logic [FN_W-1:0] code_q;

        // Word write takes precedence; otherwise a matching field-set loads the code.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q <= '0;
            else if (we && (idx == WIDX))
                code_q <= wdata[LSB +: FN_W];
            else if (fnset_hit && (fnset_pin == PIN_NUM_W'(p)))
                code_q <= fnset_code;
        end

        assign func[p*FN_W +: FN_W] = code_q;
    end
endmodule

// File: rtl/gpio_bank_mux.sv
// Module: GPIO bank top. Register port, control registers, function
// fields, input synchroniser and pad drive. Assumes 1 <= NUM_PINS <= 32.
module gpio_bank_mux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic                     bus_re,
    input  logic [IDX_W-1:0]         bus_idx,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_PINS-1:0]      pad_in,
    output logic [NUM_PINS-1:0]      pad_out,
    output logic [NUM_PINS-1:0]      pad_oe,
    output logic [NUM_PINS-1:0]      pad_pull_en,
    output logic [NUM_PINS-1:0]      pad_pull_up,
    output logic [NUM_PINS*FN_W-1:0] pad_func
);
    localparam int MUX_WORDS = (NUM_PINS + FN_PER_WRD - 1) / FN_PER_WRD;
    localparam int N_CTRL    = 4;
    localparam logic [IDX_W-1:0] CTRL_IDX [N_CTRL] = '{IDX_DIR, IDX_OUT, IDX_PEN, IDX_PUP};

    logic [NUM_PINS-1:0]        ctrl_q [N_CTRL];
    logic [NUM_PINS-1:0]        in_sync;
    logic [MUX_WORDS*DATA_W-1:0] func_words;
    logic [DATA_W-1:0]          rd_word;

    for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
        localparam logic [NUM_PINS-1:0] RV = (g == 0) ? {NUM_PINS{1'b1}} : {NUM_PINS{1'b0}};
        gpio_bit_reg #(.W(NUM_PINS), .RST_VAL(RV)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we && (bus_idx == CTRL_IDX[g])),
            .wdata (bus_wdata[NUM_PINS-1:0]),
            .q     (ctrl_q[g])
        );
    end

    gpio_mux_fields #(.NUM_PINS(NUM_PINS)) u_fields (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .idx   (bus_idx),
        .wdata (bus_wdata),
        .func  (pad_func)
    );

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    // Zero-extend the packed function fields to whole words.
    always_comb begin
        func_words = '0;
        func_words[NUM_PINS*FN_W-1:0] = pad_func;
    end

    // Pad-side drive: enable is the inverse of direction, level gated by it.
    always_comb begin
        pad_oe      = ~ctrl_q[0];
        pad_out     = ctrl_q[1] & ~ctrl_q[0];
        pad_pull_en = ctrl_q[2];
        pad_pull_up = ctrl_q[3];
    end

    // Select the addressed register; unmapped indices give zero.
    always_comb begin
        rd_word = '0;
        if (bus_idx == IDX_DIR) rd_word[NUM_PINS-1:0] = ctrl_q[0];
        if (bus_idx == IDX_OUT) rd_word[NUM_PINS-1:0] = ctrl_q[1];
        if (bus_idx == IDX_IN)  rd_word[NUM_PINS-1:0] = in_sync;
        if (bus_idx == IDX_PEN) rd_word[NUM_PINS-1:0] = ctrl_q[2];
        if (bus_idx == IDX_PUP) rd_word[NUM_PINS-1:0] = ctrl_q[3];
        for (int w = 0; w < MUX_WORDS; w++) begin
            if (bus_idx == IDX_W'(int'(IDX_MUX0) + w))
                rd_word = func_words[w*DATA_W +: DATA_W];
        end
    end

    // Register read data on a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// Module: property checker for the GPIO bank, bound to every instance.
// Assumes it observes the top-level ports only.
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_we,
    input logic                     bus_re,
    input logic [IDX_W-1:0]         bus_idx,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [NUM_PINS-1:0]      pad_out,
    input logic [NUM_PINS-1:0]      pad_oe,
    input logic [NUM_PINS-1:0]      pad_pull_en,
    input logic [NUM_PINS-1:0]      pad_pull_up,
    input logic [NUM_PINS*FN_W-1:0] pad_func
);
    localparam int MUX_WORDS = (NUM_PINS + FN_PER_WRD - 1) / FN_PER_WRD;
    localparam int LAST_MUX  = int'(IDX_MUX0) + MUX_WORDS - 1;

    logic [PIN_NUM_W-1:0]       pin_q;
    logic [MAX_PINS*FN_W-1:0]   fmask_full;
    logic                       unmapped;

    // Remember the last cycle's field-set pin number.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= bus_wdata[FNSET_LSB +: PIN_NUM_W];
    end

    // Derive the protected-field mask and the unmapped-index flag.
    always_comb begin
        fmask_full = fn_field_mask(pin_q);
        unmapped   = (bus_idx == 4'd6) || (bus_idx == 4'd7) || (int'(bus_idx) > LAST_MUX);
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0) && (pad_func == '0) && (pad_pull_en == '0));

    p_oe_from_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_DIR) |=> pad_oe == ~$past(bus_wdata[NUM_PINS-1:0]));

    p_out_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    p_pull_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_PUP) |=> pad_pull_up == $past(bus_wdata[NUM_PINS-1:0]));

    p_fnset_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_FNSET) |=>
            ((pad_func ^ $past(pad_func)) & ~fmask_full[NUM_PINS*FN_W-1:0]) == '0);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && unmapped) |=> bus_rdata == '0);

    p_pull_en_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && unmapped) |=> $stable(pad_pull_en) && $stable(pad_oe));
endmodule

bind gpio_bank_mux gpio_bank_checker #(.NUM_PINS(NUM_PINS)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_idx     (bus_idx),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up),
    .pad_func    (pad_func)
);

// File: tb/test_gpio_bank_mux.sv
// Bench: table of write/read-back vectors, then directed checks.
module test_gpio_bank_mux;
    localparam int N    = 20;
    localparam int FW   = N * 4;
    localparam logic [31:0] PMASK = 32'h000F_FFFF;
    localparam int NVEC = 12;

    // {index, write data, expected read-back}
    localparam logic [67:0] VEC [NVEC] = '{
        {4'h0, 32'hFFFF_0F0F, 32'h000F_0F0F},
        {4'h1, 32'h1234_5678, 32'h0004_5678},
        {4'h3, 32'hFFFF_FFFF, 32'h000F_FFFF},
        {4'h4, 32'h000A_5A5A, 32'h000A_5A5A},
        {4'h8, 32'h8765_4321, 32'h8765_4321},
        {4'h9, 32'hFEDC_BA98, 32'hFEDC_BA98},
        {4'hA, 32'hFFFF_FFFF, 32'h0000_FFFF},
        {4'h2, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'h6, 32'hDEAD_BEEF, 32'h0000_0000},
        {4'hB, 32'h1234_5678, 32'h0000_0000},
        {4'hF, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'h1, 32'h000A_BCDE, 32'h000A_BCDE}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [3:0]    bus_idx = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [FW-1:0] pad_func;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;
    logic [31:0] dir_v, out_v;

    always #4 clk = ~clk;

    gpio_bank_mux #(.NUM_PINS(N)) i_gpio_bank_mux (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_func(pad_func)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:       return "R10";
            2, 3:       return "R4";
            4, 5, 6:    return "R5";
            7:          return "R7";
            8, 9, 10:   return "R9";
            default:    return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] idx, output logic [31:0] d);
        bus_re = 1'b1; bus_idx = idx;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdreg(4'h0, rd); check("R1 dir", rd, PMASK);
        rdreg(4'h1, rd); check("R1 out", rd, 0);
        rdreg(4'h3, rd); check("R1 pull_en", rd, 0);
        rdreg(4'h8, rd); check("R1 mux0", rd, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pad_func", pad_func, 0);

        // Table walk: write, then read back.
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rdreg(VEC[i][67:64], rd);
            check(vec_tag(i), rd, VEC[i][31:0]);
        end

        // R2 / R3 pad drive from direction and output level
        dir_v = 32'h000F_0F0F; out_v = 32'h000A_BCDE;
        check("R2 pad_oe", pad_oe, ~dir_v & PMASK);
        check("R3 pad_out", pad_out, out_v & ~dir_v & PMASK);
        // R4 pull pins
        check("R4 pad_pull_en", pad_pull_en, PMASK);
        check("R4 pad_pull_up", pad_pull_up, 32'h000A_5A5A);
        // R5 function fields on pads
        check("R5 pad_func", pad_func, {16'hFFFF, 32'hFEDC_BA98, 32'h8765_4321});

        // R6 single-field set: pin 9 gets code 3
        wr(4'h5, 32'h0000_0903);
        rdreg(4'h9, rd); check("R6 target word", rd, 32'hFEDC_BA38);
        rdreg(4'h8, rd); check("R6 neighbour word", rd, 32'h8765_4321);
        // R6 out-of-range pin 25 ignored
        wr(4'h5, 32'h0000_1907);
        check("R6 out-of-range", pad_func, {16'hFFFF, 32'hFEDC_BA38, 32'h8765_4321});
        rdreg(4'h5, rd); check("R6 reads zero", rd, 0);

        // R7 synchroniser latency
        pad_in = 20'h5A5A5;
        rdreg(4'h2, rd); check("R7 edge1 old", rd, 0);
        rdreg(4'h2, rd); check("R7 edge2 old", rd, 0);
        rdreg(4'h2, rd); check("R7 edge3 new", rd, 32'h0005_A5A5);

        // R9 unmapped write leaves state untouched
        wr(4'h7, 32'h0000_0000);
        wr(4'hC, 32'h0000_0000);
        rdreg(4'h0, rd); check("R9 dir kept", rd, dir_v);
        rdreg(4'h4, rd); check("R9 pull_up kept", rd, 32'h000A_5A5A);

        // R8 read data holds without a read
        rdreg(4'h1, rd); check("R8 read", rd, out_v);
        wr(4'h0, 32'h0000_0000);
        @(negedge clk);
        check("R8 hold", bus_rdata, out_v);
        check("R2 all outputs", pad_oe, PMASK);
        check("R3 all driven", pad_out, out_v);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule